// File: doc/BRIEF.md
# Motion Event Engine

This block watches a stream of signed acceleration samples, one value per axis, and flags two kinds of event. An activity event means at least one axis has moved past a programmable level. An inactivity event means every axis has stayed at or below a second level for a programmable run of valid samples. Each detector can work on the raw sample magnitude or on the distance from a reference sample. The reference is captured when that detector is armed.

The two detectors can run side by side, or be chained so that only one of them is armed at a time. In the chained arrangement the hand-over to the other detector happens in one of two ways. In linked operation it waits until the host has acknowledged the pending event by reading the status register. In looped operation the event is acknowledged inside the block, and the other detector is armed at once. Software uses a byte-wide register port to set the control byte, both thresholds and the dwell length, and to read and clear the status. Two interrupt outputs follow the latched event flags.

Top module: `motion_event_engine`

## Requirements
- R1: The control register is at address 0x27 and resets to 0x00. Bit 0 enables activity detection. Bit 1 selects referenced activity comparison (1) or absolute comparison (0). Bit 2 enables inactivity detection. Bit 3 selects referenced inactivity comparison (1) or absolute comparison (0). Bits [5:4] hold the link mode. Bits [7:6] ignore writes and read as zero.
- R2: An absolute activity event occurs on a valid sample where any axis has a magnitude strictly above the activity threshold (address 0x20). The activity flag and `int_act` are high in the cycle after that sample.
- R3: An inactivity event needs N consecutive valid samples in which every axis is at or below the inactivity threshold (address 0x21). N is the dwell register at address 0x22, and a dwell of 0 counts as 1. Any sample above the threshold restarts the count. Cycles without `smp_valid` neither advance nor restart the count.
- R4: In referenced mode, the first valid sample after a detector is armed is stored as that detector's reference and is not judged. Each later sample is compared per axis as |sample − reference|.
- R5: In free mode both detectors run independently. A latched event flag stays high until a status read.
- R6: The status register is at address 0x0B. Bit 0 is the activity flag, bit 1 the inactivity flag and bit 6 the awake flag. A read returns the current value and then clears bits 0 and 1, unless an event sets one of them in the same cycle. The awake flag is set by an activity event, cleared by an inactivity event, and is not touched by reads.
- R7: Linked mode is link field 01 with both enables set. Activity is armed first, and only one detector is armed at a time. After an event, the block waits for that flag to be cleared by a status read before it arms the other detector.
- R8: Looped mode is link field 11 with both enables set. The detectors alternate immediately after each event. Each event flag, and the interrupt that follows it, is high for exactly one cycle.
- R9: Link field 00 or 10, or either enable at 0, gives free mode whatever the link field holds.
- R10: `reg_rdata` is registered and valid in the cycle after `reg_re`. The threshold and dwell registers read back what was written. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | AXES*DW | Signed samples; axis i in bits [i*DW +: DW], axis 0 lowest |
| int_act | output | 1 | Activity event flag |
| int_inact | output | 1 | Inactivity event flag |

## Verification
The assertions assume that `reg_we` and `reg_re` never share a cycle. They also assume that the control byte is not rewritten in the cycle a chained detector hands over, so that the link mode seen by the sequencer is steady across each event. The bench keeps within these assumptions by issuing every register access and every sample through separate one-operation tasks, each occupying its own cycle. It changes the link mode only while no samples are flowing, and clears the status before each new mode is tried.

// File: rtl/motion_pkg.sv
package motion_pkg;

  localparam logic [7:0] ADDR_STATUS     = 8'h0B;
  localparam logic [7:0] ADDR_ACT_THR    = 8'h20;
  localparam logic [7:0] ADDR_INACT_THR  = 8'h21;
  localparam logic [7:0] ADDR_INACT_TIME = 8'h22;
  localparam logic [7:0] ADDR_CTRL       = 8'h27;

  typedef struct packed {
    logic [1:0] spare;
    logic [1:0] link;
    logic       inact_ref;
    logic       inact_en;
    logic       act_ref;
    logic       act_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEQ_FREE,
    SEQ_LINKED,
    SEQ_LOOPED
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_ACT,
    ST_ACT_WAIT,
    ST_INACT,
    ST_INACT_WAIT
  } seq_state_e;

endpackage

// File: rtl/me_regs.sv
module me_regs
  import motion_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output ctrl_t         ctrl,
  output logic [TW-1:0] act_thr,
  output logic [TW-1:0] inact_thr,
  output logic [TW-1:0] inact_time,
  input  logic          act_evt,
  input  logic          inact_evt,
  input  logic          loop_mode,
  output logic          act_flag,
  output logic          inact_flag,
  output logic          awake
);

  logic status_rd;
  assign status_rd = reg_re && (reg_addr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      act_thr    <= '0;
      inact_thr  <= '0;
      inact_time <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_CTRL:       ctrl       <= ctrl_t'({2'b00, reg_wdata[5:0]});
        ADDR_ACT_THR:    act_thr    <= reg_wdata[TW-1:0];
        ADDR_INACT_THR:  inact_thr  <= reg_wdata[TW-1:0];
        ADDR_INACT_TIME: inact_time <= reg_wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        ADDR_CTRL:       reg_rdata <= ctrl;
        ADDR_ACT_THR:    reg_rdata <= 8'(act_thr);
        ADDR_INACT_THR:  reg_rdata <= 8'(inact_thr);
        ADDR_INACT_TIME: reg_rdata <= 8'(inact_time);
        ADDR_STATUS:     reg_rdata <= {1'b0, awake, 4'b0000, inact_flag, act_flag};
        default:         reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_flag   <= 1'b0;
      inact_flag <= 1'b0;
      awake      <= 1'b0;
    end else begin
      act_flag   <= act_evt   | (act_flag   & ~loop_mode & ~status_rd);
      inact_flag <= inact_evt | (inact_flag & ~loop_mode & ~status_rd);
      if (act_evt)
        awake <= 1'b1;
      else if (inact_evt)
        awake <= 1'b0;
    end
  end

  a_r1_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == ADDR_CTRL) |=> (reg_rdata[7:6] == 2'b00));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !act_evt && !inact_evt) |=> (!act_flag && !inact_flag));

  a_r6_awake_on_act: assert property (@(posedge clk) disable iff (rst)
    act_evt |=> awake);

  a_r8_loop_pulse: assert property (@(posedge clk) disable iff (rst)
    (loop_mode && act_flag && !act_evt) |=> !act_flag);

endmodule

// File: rtl/me_detector.sv
module me_detector #(
  parameter int DW     = 12,
  parameter int AXES   = 3,
  parameter int TW     = 8,
  parameter bit IS_ACT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 ref_mode,
  input  logic [TW-1:0]        thr,
  input  logic [TW-1:0]        dwell,
  input  logic                 smp_valid,
  input  logic [AXES*DW-1:0]   smp_data,
  output logic                 evt
);

  localparam int MW = DW + 1;

  logic            prev_active;
  logic            need_ref;
  logic            arm;
  logic            take_ref;
  logic            judge;
  logic [AXES-1:0] over;

  assign arm      = active & ~prev_active;
  assign take_ref = active & smp_valid & (arm | need_ref);
  assign judge    = active & smp_valid & ~(ref_mode & (arm | need_ref));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_active <= 1'b0;
      need_ref    <= 1'b0;
    end else begin
      prev_active <= active;
      need_ref    <= active & (arm | need_ref) & ~smp_valid;
    end
  end

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    logic signed [DW-1:0] s_ax;
    logic signed [DW-1:0] r_ax;
    logic signed [MW-1:0] diff;
    logic        [MW-1:0] mag;

    assign s_ax = smp_data[i*DW +: DW];

    always_ff @(posedge clk) begin
      if (rst)
        r_ax <= '0;
      else if (take_ref)
        r_ax <= s_ax;
    end

    assign diff    = ref_mode ? (MW'(s_ax) - MW'(r_ax)) : MW'(s_ax);
    assign mag     = diff[MW-1] ? $unsigned(-diff) : $unsigned(diff);
    assign over[i] = mag > MW'(thr);
  end

  if (IS_ACT) begin : g_act
    logic unused_dwell;
    assign unused_dwell = ^dwell;
    assign evt = judge & (|over);
  end else begin : g_inact
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_base;
    logic [TW:0]   need;
    logic [TW:0]   nxt;

    assign need     = (dwell == '0) ? (TW+1)'(1) : {1'b0, dwell};
    assign cnt_base = arm ? '0 : cnt_q;
    assign nxt      = {1'b0, cnt_base} + (TW+1)'(1);
    assign evt      = judge & ~(|over) & (nxt >= need);

    always_ff @(posedge clk) begin
      if (rst || !active)
        cnt_q <= '0;
      else if (judge)
        cnt_q <= ((|over) || evt) ? '0 : nxt[TW-1:0];
      else
        cnt_q <= cnt_base;
    end

    a_r3_over_restarts: assert property (@(posedge clk) disable iff (rst)
      (judge && (|over)) |=> (cnt_q == '0));
  end

  a_r2_evt_on_valid: assert property (@(posedge clk) disable iff (rst)
    evt |-> (active && smp_valid));

  a_r4_ref_sample_silent: assert property (@(posedge clk) disable iff (rst)
    (ref_mode && take_ref) |-> !evt);

endmodule

// File: rtl/me_link_seq.sv
module me_link_seq
  import motion_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       act_en,
  input  logic       inact_en,
  input  logic [1:0] link,
  input  logic       act_evt,
  input  logic       inact_evt,
  input  logic       act_flag,
  input  logic       inact_flag,
  output logic       act_active,
  output logic       inact_active,
  output logic       loop_mode
);

  seq_mode_e  mode;
  seq_state_e st;

  always_comb begin
    mode = SEQ_FREE;
    if (act_en && inact_en) begin
      if (link == 2'b01)
        mode = SEQ_LINKED;
      else if (link == 2'b11)
        mode = SEQ_LOOPED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode == SEQ_FREE) begin
      st <= ST_ACT;
    end else begin
      case (st)
        ST_ACT:        if (act_evt)     st <= (mode == SEQ_LOOPED) ? ST_INACT : ST_ACT_WAIT;
        ST_ACT_WAIT:   if (!act_flag)   st <= ST_INACT;
        ST_INACT:      if (inact_evt)   st <= (mode == SEQ_LOOPED) ? ST_ACT : ST_INACT_WAIT;
        ST_INACT_WAIT: if (!inact_flag) st <= ST_ACT;
        default:                        st <= ST_ACT;
      endcase
    end
  end

  assign act_active   = (mode == SEQ_FREE) ? act_en   : (st == ST_ACT);
  assign inact_active = (mode == SEQ_FREE) ? inact_en : (st == ST_INACT);
  assign loop_mode    = (mode == SEQ_LOOPED);

  a_r7_one_armed: assert property (@(posedge clk) disable iff (rst)
    (mode != SEQ_FREE) |-> !(act_active && inact_active));

  a_r7_hold_for_ack: assert property (@(posedge clk) disable iff (rst)
    (mode == SEQ_LINKED && st == ST_ACT_WAIT && act_flag) |=> (st == ST_ACT_WAIT));

  a_r8_loop_advance: assert property (@(posedge clk) disable iff (rst)
    (mode == SEQ_LOOPED && st == ST_ACT && act_evt) |=> (st == ST_INACT));

endmodule

// File: rtl/motion_event_engine.sv
module motion_event_engine
  import motion_pkg::*;
#(
  parameter int DW   = 12,
  parameter int AXES = 3,
  parameter int TW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               smp_valid,
  input  logic [AXES*DW-1:0] smp_data,
  output logic               int_act,
  output logic               int_inact
);

  ctrl_t         ctrl;
  logic [TW-1:0] act_thr;
  logic [TW-1:0] inact_thr;
  logic [TW-1:0] inact_time;
  logic          act_evt;
  logic          inact_evt;
  logic          act_flag;
  logic          inact_flag;
  logic          awake;
  logic          act_active;
  logic          inact_active;
  logic          loop_mode;

  me_regs #(.TW(TW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ctrl       (ctrl),
    .act_thr    (act_thr),
    .inact_thr  (inact_thr),
    .inact_time (inact_time),
    .act_evt    (act_evt),
    .inact_evt  (inact_evt),
    .loop_mode  (loop_mode),
    .act_flag   (act_flag),
    .inact_flag (inact_flag),
    .awake      (awake)
  );

  me_link_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .act_en       (ctrl.act_en),
    .inact_en     (ctrl.inact_en),
    .link         (ctrl.link),
    .act_evt      (act_evt),
    .inact_evt    (inact_evt),
    .act_flag     (act_flag),
    .inact_flag   (inact_flag),
    .act_active   (act_active),
    .inact_active (inact_active),
    .loop_mode    (loop_mode)
  );

  me_detector #(.DW(DW), .AXES(AXES), .TW(TW), .IS_ACT(1'b1)) u_act_det (
    .clk       (clk),
    .rst       (rst),
    .active    (act_active),
    .ref_mode  (ctrl.act_ref),
    .thr       (act_thr),
    .dwell     (inact_time),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .evt       (act_evt)
  );

  me_detector #(.DW(DW), .AXES(AXES), .TW(TW), .IS_ACT(1'b0)) u_inact_det (
    .clk       (clk),
    .rst       (rst),
    .active    (inact_active),
    .ref_mode  (ctrl.inact_ref),
    .thr       (inact_thr),
    .dwell     (inact_time),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .evt       (inact_evt)
  );

  assign int_act   = act_flag;
  assign int_inact = inact_flag;

  a_r6_awake_on_inact: assert property (@(posedge clk) disable iff (rst)
    (inact_evt && !act_evt) |=> !awake);

endmodule

// File: tb/motion_event_engine_bench.sv
module motion_event_engine_bench;

  localparam int DW   = 12;
  localparam int AXES = 3;
  localparam int NV   = 8;

  localparam int VX [NV] = '{0, 100, 101,    0,    0,  50, -2048,  99};
  localparam int VY [NV] = '{0,   0,   0, -101,    0, -50,     0, -99};
  localparam int VZ [NV] = '{0,   0,   0,    0, -100, 2047,    0,  99};
  localparam int VE [NV] = '{0,   0,   1,    1,    0,   1,     1,   0};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               reg_we = 1'b0;
  logic               reg_re = 1'b0;
  logic [7:0]         reg_addr = '0;
  logic [7:0]         reg_wdata = '0;
  logic [7:0]         reg_rdata;
  logic               smp_valid = 1'b0;
  logic [AXES*DW-1:0] smp_data = '0;
  logic               int_act;
  logic               int_inact;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  awake_m = 1'b0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  motion_event_engine #(.DW(DW), .AXES(AXES), .TW(8)) u_motion_event_engine (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .int_act   (int_act),
    .int_inact (int_inact)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic smp(input int x, input int y, input int z);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = {DW'(z), DW'(y), DW'(x)};
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1 int_act after reset", {7'b0, int_act}, 8'h00);
    chk("R1 int_inact after reset", {7'b0, int_inact}, 8'h00);
    rd(8'h27, rv); chk("R1 control reset", rv, 8'h00);
    rd(8'h0B, rv); chk("R6 status reset", rv, 8'h00);
    wr(8'h27, 8'hFF);
    rd(8'h27, rv); chk("R1 spare bits read zero", rv, 8'h3F);
    wr(8'h27, 8'h00);
    wr(8'h21, 8'h33);
    rd(8'h21, rv); chk("R10 threshold readback", rv, 8'h33);
    rd(8'h30, rv); chk("R10 unmapped reads zero", rv, 8'h00);

    // vector table: absolute activity, R2 and R6
    wr(8'h20, 8'd100);
    wr(8'h27, 8'h01);
    for (int i = 0; i < NV; i++) begin
      smp(VX[i], VY[i], VZ[i]);
      chk("R2 activity vector", {7'b0, int_act}, 8'(VE[i]));
      if (VE[i] != 0) awake_m = 1'b1;
      rd(8'h0B, rv);
      chk("R6 status after vector", rv, {1'b0, awake_m, 5'b0, 1'(VE[i])});
    end

    // R3 absolute inactivity with dwell 3
    wr(8'h21, 8'd20);
    wr(8'h22, 8'd3);
    wr(8'h27, 8'h04);
    smp(5, -5, 0);
    smp(0, 20, -20);
    chk("R3 two quiet samples", {7'b0, int_inact}, 8'h00);
    smp(0, 0, 30);
    chk("R3 loud sample", {7'b0, int_inact}, 8'h00);
    smp(1, 1, 1);
    smp(-1, 0, 2);
    chk("R3 count restarted", {7'b0, int_inact}, 8'h00);
    repeat (3) @(negedge clk);
    smp(0, 0, 0);
    chk("R3 third quiet sample fires", {7'b0, int_inact}, 8'h01);
    awake_m = 1'b0;
    rd(8'h0B, rv); chk("R6 inactivity status", rv, 8'h02);
    rd(8'h0B, rv); chk("R6 read cleared flags", rv, 8'h00);

    // R4 referenced activity
    wr(8'h20, 8'd50);
    wr(8'h27, 8'h03);
    smp(500, 0, 0);
    chk("R4 reference sample not judged", {7'b0, int_act}, 8'h00);
    smp(540, 0, 0);
    chk("R4 diff 40 below threshold", {7'b0, int_act}, 8'h00);
    smp(560, 0, 0);
    chk("R4 diff 60 above threshold", {7'b0, int_act}, 8'h01);
    rd(8'h0B, rv); chk("R4 status", rv, 8'h41);

    // R7 linked mode
    wr(8'h20, 8'd100);
    wr(8'h22, 8'd2);
    wr(8'h27, 8'h15);
    smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0);
    chk("R7 inactivity not armed first", {7'b0, int_inact}, 8'h00);
    smp(200, 0, 0);
    chk("R7 activity armed first", {7'b0, int_act}, 8'h01);
    smp(0, 0, 0); smp(0, 0, 0); smp(0, 0, 0);
    chk("R7 waits for status read", {7'b0, int_inact}, 8'h00);
    rd(8'h0B, rv); chk("R7 status before hand-over", rv, 8'h41);
    smp(0, 0, 0); smp(0, 0, 0);
    chk("R7 inactivity armed after read", {7'b0, int_inact}, 8'h01);
    smp(200, 0, 0);
    chk("R7 activity disarmed while waiting", {7'b0, int_act}, 8'h00);
    rd(8'h0B, rv); chk("R7 inactivity status", rv, 8'h02);
    smp(200, 0, 0);
    chk("R7 activity rearmed", {7'b0, int_act}, 8'h01);

    // R8 looped mode
    wr(8'h27, 8'h00);
    rd(8'h0B, rv);
    wr(8'h27, 8'h35);
    smp(200, 0, 0);
    chk("R8 activity pulse high", {7'b0, int_act}, 8'h01);
    @(negedge clk);
    chk("R8 activity pulse one cycle", {7'b0, int_act}, 8'h00);
    smp(0, 0, 0); smp(0, 0, 0);
    chk("R8 inactivity armed at once", {7'b0, int_inact}, 8'h01);
    @(negedge clk);
    chk("R8 inactivity pulse one cycle", {7'b0, int_inact}, 8'h00);
    rd(8'h0B, rv); chk("R8 flags self-cleared", rv, 8'h00);
    smp(200, 0, 0);
    chk("R8 activity armed again", {7'b0, int_act}, 8'h01);

    // R9 link field 10 is free mode; R5 both run and hold
    wr(8'h27, 8'h00);
    rd(8'h0B, rv);
    wr(8'h27, 8'h25);
    smp(0, 0, 0); smp(0, 0, 0);
    chk("R9 inactivity runs in free mode", {7'b0, int_inact}, 8'h01);
    smp(200, 0, 0);
    chk("R5 activity runs alongside", {7'b0, int_act}, 8'h01);
    chk("R5 inactivity flag held", {7'b0, int_inact}, 8'h01);
    rd(8'h0B, rv); chk("R5 status both flags", rv, 8'h43);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule